// File: doc/BRIEF.md
# Gate-Driver Control Register Port with Frame Length Check

This block is the serial access point to a small set of registers in a motor gate-driver controller. A host selects it with an active-low chip select and sends one 16-bit word per selection. The word is clocked in on the falling edges of a serial clock, most significant bit first. The block counts the clock edges in each selection. When the selection ends, a word of exactly 16 bits is decoded into an access type, a register address and a data field. Any other length is rejected and reported in the next response.

The control registers feed the gate-drive logic in parallel. They are loaded only from a latched and length-checked word, one system clock after chip select returns high. A stream of bits, or a frame that is cut short or too long, can therefore never disturb the gate settings. Status registers hold read-only inputs that the host can read back.

Each frame also carries a response out on the serial data output. That response holds the fault flag, the address used by the previous valid frame, and that register's contents. All serial inputs pass through synchronizers into the system clock domain, so the system clock must run at least four times faster than the serial clock.

Top module: `gdrv_spi_regs`

## Requirements
- R1: While chip select is low, one input bit is taken on each falling serial clock edge, most significant bit first. In the 16-bit word, bit 15 is the access type (1 = read, 0 = write), bits 14:11 are the register address and bits 10:0 are the data.
- R2: Any idle time between clock edges inside one selection is allowed, so two 8-bit bursts with a pause between them form one valid frame.
- R3: A valid write to a control address (0 to NUM_CTRL-1) appears on that register's slice of `ctrl_o` after chip select rises. `ctrl_o` never changes while chip select is low.
- R4: A selection with any number of falling clock edges other than 16, zero included, changes no register.
- R5: After a frame of the wrong length, bit 15 of the next response word is 1.
- R6: The fault flag clears once a response word that carried it has been clocked out with at least 16 rising clock edges, unless that same frame has the wrong length.
- R7: The response shifted out during a frame is {fault, address, 11-bit data}. The address and data are those of the register named by the last valid frame (address 0 after reset). Bit 15 goes out first, and each bit is driven after a rising serial clock edge. `spi_sdo` is 0 while the block is deselected.
- R8: Addresses NUM_CTRL to NUM_CTRL+NUM_STAT-1 read slices of `stat_i` (lowest slice first) and ignore writes. Higher addresses ignore writes and read data 0.
- R9: After reset, all control registers are 0, the response address is 0 and the fault flag is 0.
- R10: A valid read frame leaves every control register unchanged, whatever its data bits hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_csn | input | 1 | Active-low chip select |
| spi_sclk | input | 1 | Serial clock, idles low |
| spi_sdi | input | 1 | Serial data into the block |
| spi_sdo | output | 1 | Serial response data |
| stat_i | input | NUM_STAT*11 | Read-only status values |
| ctrl_o | output | NUM_CTRL*11 | Committed control register contents |

## Verification
A wrong bit count or a bad latch shows up on the control outputs a dozen system clocks after chip select rises, as a rejected write that lands or a valid write that is lost. A wrong response address or fault flag shows up on the serial output during the very next frame, so every frame is checked against a model of the previous one. Mid-frame corruption of the outputs is caught by looking at them during a long pause inside a split frame.

// File: rtl/gdrv_spi_pkg.sv
package gdrv_spi_pkg;
   localparam int FRAME_BITS = 16;
   localparam int ADDR_BITS  = 4;
   localparam int DATA_BITS  = 11;
   localparam int CNT_W      = $clog2(FRAME_BITS + 2);
   localparam int CNT_MAX    = FRAME_BITS + 1;

   typedef struct packed {
      logic                 rd;
      logic [ADDR_BITS-1:0] addr;
      logic [DATA_BITS-1:0] data;
   } spi_word_t;
endpackage

// File: rtl/gdrv_spi_sync.sv
module gdrv_spi_sync #(
   parameter int           STAGES  = 2,
   parameter int           W       = 1,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain[s] <= RST_VAL;
         end else begin
            if (s == 0) chain[s] <= d;
            else        chain[s] <= chain[(s == 0) ? 0 : s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/gdrv_spi_frame_rx.sv
module gdrv_spi_frame_rx
   import gdrv_spi_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             fall_i,
   input  logic             bit_i,
   input  logic             stop_i,
   output spi_word_t        word_o,
   output logic             ok_o,
   output logic             err_o,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);
   localparam logic [CNT_W-1:0] SAT  = CNT_W'(CNT_MAX);

   logic [FRAME_BITS-1:0] shreg;
   logic [FRAME_BITS-1:0] hold;
   logic [CNT_W-1:0]      cnt;
   logic [FRAME_BITS-1:0] next_sh;

   assign next_sh = {shreg[FRAME_BITS-2:0], bit_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         hold  <= '0;
         cnt   <= '0;
      end else if (start_i) begin
         cnt <= '0;
      end else if (fall_i) begin
         shreg <= next_sh;
         if (cnt != SAT) cnt <= cnt + 1'b1;
         if (cnt == LAST) hold <= next_sh;
      end else if (stop_i && (cnt < FULL)) begin
         hold <= shreg;
      end
   end

   assign word_o = spi_word_t'(hold);
   assign ok_o   = stop_i && (cnt == FULL);
   assign err_o  = stop_i && (cnt != FULL);
   assign cnt_o  = cnt;
endmodule

// File: rtl/gdrv_spi_tx.sv
module gdrv_spi_tx
   import gdrv_spi_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_i,
   input  logic                  start_i,
   input  logic                  rise_i,
   input  logic [FRAME_BITS-1:0] word_i,
   output logic                  sdo_o,
   output logic                  done_o
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

   logic [FRAME_BITS-1:0] sh;
   logic [CNT_W-1:0]      rc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh    <= '0;
         rc    <= '0;
         sdo_o <= 1'b0;
      end else if (!sel_i) begin
         sdo_o <= 1'b0;
      end else if (start_i) begin
         sh    <= word_i;
         rc    <= '0;
         sdo_o <= 1'b0;
      end else if (rise_i) begin
         sdo_o <= sh[FRAME_BITS-1];
         sh    <= {sh[FRAME_BITS-2:0], 1'b0};
         if (rc != FULL) rc <= rc + 1'b1;
      end
   end

   assign done_o = (rc == FULL);
endmodule

// File: rtl/gdrv_spi_regfile.sv
module gdrv_spi_regfile
   import gdrv_spi_pkg::*;
#(
   parameter int NUM_CTRL = 2,
   parameter int NUM_STAT = 2,
   localparam int CW = NUM_CTRL * DATA_BITS,
   localparam int SW = NUM_STAT * DATA_BITS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start_i,
   input  logic                  ok_i,
   input  logic                  err_i,
   input  logic                  stop_i,
   input  logic                  sent_i,
   input  spi_word_t             word_i,
   input  logic [SW-1:0]         stat_i,
   output logic [CW-1:0]         ctrl_o,
   output logic [FRAME_BITS-1:0] resp_o,
   output logic [NUM_CTRL-1:0]   wr_en_o,
   output logic                  fault_o
);
   logic [DATA_BITS-1:0] ctrl_q [NUM_CTRL];
   logic [ADDR_BITS-1:0] resp_addr;
   logic [DATA_BITS-1:0] rdata;
   logic                 fault_q;
   logic                 fault_sent;

   for (genvar i = 0; i < NUM_CTRL; i++) begin : g_ctrl
      assign wr_en_o[i] = ok_i && !word_i.rd && (word_i.addr == ADDR_BITS'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          ctrl_q[i] <= '0;
         else if (wr_en_o[i]) ctrl_q[i] <= word_i.data;
      end
      assign ctrl_o[i*DATA_BITS +: DATA_BITS] = ctrl_q[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_addr  <= '0;
         fault_q    <= 1'b0;
         fault_sent <= 1'b0;
      end else begin
         if (start_i) fault_sent <= fault_q;
         if (ok_i)    resp_addr  <= word_i.addr;
         if (err_i)   fault_q <= 1'b1;
         else if (stop_i && fault_sent && sent_i) fault_q <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      for (int c = 0; c < NUM_CTRL; c++)
         if (resp_addr == ADDR_BITS'(c)) rdata = ctrl_q[c];
      for (int s = 0; s < NUM_STAT; s++)
         if (resp_addr == ADDR_BITS'(NUM_CTRL + s)) rdata = stat_i[s*DATA_BITS +: DATA_BITS];
   end

   assign resp_o  = {fault_q, resp_addr, rdata};
   assign fault_o = fault_q;
endmodule

// File: rtl/gdrv_spi_regs.sv
module gdrv_spi_regs
   import gdrv_spi_pkg::*;
#(
   parameter int NUM_CTRL    = 2,
   parameter int NUM_STAT    = 2,
   parameter int SYNC_STAGES = 2,
   localparam int CW = NUM_CTRL * DATA_BITS,
   localparam int SW = NUM_STAT * DATA_BITS
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          spi_csn,
   input  logic          spi_sclk,
   input  logic          spi_sdi,
   output logic          spi_sdo,
   input  logic [SW-1:0] stat_i,
   output logic [CW-1:0] ctrl_o
);
   if (NUM_CTRL < 1 || NUM_STAT < 1 || (NUM_CTRL + NUM_STAT) > (1 << ADDR_BITS)) begin : g_bad_map
      $error("register map does not fit the address field");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end

   logic [2:0]            pins_s;
   logic                  sel, sel_d, sclk_s, sclk_d, sdi_s;
   logic                  cs_fall, cs_rise, clk_fall, clk_rise;
   spi_word_t             rx_word;
   logic                  rx_ok, rx_err, tx_done, fault_q;
   logic [CNT_W-1:0]      rx_cnt;
   logic [FRAME_BITS-1:0] resp_word;
   logic [NUM_CTRL-1:0]   wr_en;

   gdrv_spi_sync #(.STAGES(SYNC_STAGES), .W(3), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({spi_csn, spi_sclk, spi_sdi}), .q(pins_s)
   );

   assign sel    = ~pins_s[2];
   assign sclk_s = pins_s[1];
   assign sdi_s  = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_d  <= 1'b0;
         sclk_d <= 1'b0;
      end else begin
         sel_d  <= sel;
         sclk_d <= sclk_s;
      end
   end

   assign cs_fall  = sel & ~sel_d;
   assign cs_rise  = ~sel & sel_d;
   assign clk_fall = sel & sel_d & sclk_d & ~sclk_s;
   assign clk_rise = sel & sel_d & ~sclk_d & sclk_s;

   gdrv_spi_frame_rx u_rx (
      .clk(clk), .rst_n(rst_n), .start_i(cs_fall), .fall_i(clk_fall),
      .bit_i(sdi_s), .stop_i(cs_rise), .word_o(rx_word), .ok_o(rx_ok),
      .err_o(rx_err), .cnt_o(rx_cnt)
   );

   gdrv_spi_tx u_tx (
      .clk(clk), .rst_n(rst_n), .sel_i(sel), .start_i(cs_fall),
      .rise_i(clk_rise), .word_i(resp_word), .sdo_o(spi_sdo), .done_o(tx_done)
   );

   gdrv_spi_regfile #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT)) u_regs (
      .clk(clk), .rst_n(rst_n), .start_i(cs_fall), .ok_i(rx_ok),
      .err_i(rx_err), .stop_i(cs_rise), .sent_i(tx_done), .word_i(rx_word),
      .stat_i(stat_i), .ctrl_o(ctrl_o), .resp_o(resp_word),
      .wr_en_o(wr_en), .fault_o(fault_q)
   );
endmodule

// File: rtl/gdrv_spi_regs_chk.sv
module gdrv_spi_regs_chk
   import gdrv_spi_pkg::*;
#(
   parameter int NUM_CTRL = 2,
   parameter int CW       = 22
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sel,
   input logic                sel_d,
   input logic                sdo,
   input logic [CW-1:0]       ctrl,
   input logic [CNT_W-1:0]    rx_cnt,
   input logic                fault_q,
   input logic [NUM_CTRL-1:0] wr_en
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

   assert_ctrl_frozen_in_frame_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sel |=> $stable(ctrl));

   assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(wr_en));

   assert_bad_length_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_d && !sel && rx_cnt != FULL) |=> $stable(ctrl));

   assert_bad_length_sets_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_d && !sel && rx_cnt != FULL) |=> fault_q);

   assert_sdo_quiet_when_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> (sdo == 1'b0));
endmodule

bind gdrv_spi_regs gdrv_spi_regs_chk #(.NUM_CTRL(NUM_CTRL), .CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel(sel), .sel_d(sel_d), .sdo(spi_sdo),
   .ctrl(ctrl_o), .rx_cnt(rx_cnt), .fault_q(fault_q), .wr_en(wr_en)
);

// File: tb/gdrv_spi_regs_tb_top.sv
module gdrv_spi_regs_tb_top;
   localparam int NC = 2;
   localparam int NS = 2;
   localparam int DB = 11;
   localparam int H  = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic csn = 1'b1, sclk = 1'b0, sdi = 1'b0;
   logic sdo;
   logic [NS*DB-1:0] stat = {11'h5A3, 11'h0C7};
   logic [NC*DB-1:0] ctrl;

   always #2 clk = ~clk;

   gdrv_spi_regs #(.NUM_CTRL(NC), .NUM_STAT(NS), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .spi_csn(csn), .spi_sclk(sclk), .spi_sdi(sdi),
      .spi_sdo(sdo), .stat_i(stat), .ctrl_o(ctrl)
   );

   int checks = 0;
   int fails  = 0;
   logic [10:0] m_ctrl [NC];
   logic [3:0]  m_addr = '0;
   logic        m_fault = 1'b0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rsp();
      logic [10:0] d;
      if (m_addr < NC)           d = m_ctrl[m_addr];
      else if (m_addr < NC + NS) d = stat[(int'(m_addr) - NC)*DB +: DB];
      else                       d = '0;
      return {m_fault, m_addr, d};
   endfunction

   function automatic logic [15:0] mkw(input logic rd, input int a, input logic [10:0] d);
      return {rd, 4'(a), d};
   endfunction

   task automatic check_ctrl(input string tag);
      for (int i = 0; i < NC; i++) chk(tag, 32'(ctrl[i*DB +: DB]), 32'(m_ctrl[i]));
   endtask

   task automatic xfer(input int nbits, input logic [31:0] bits, input int gap_at,
                       output logic [15:0] rsp);
      rsp = '0;
      @(negedge clk) csn = 1'b0;
      repeat (H) @(negedge clk);
      for (int i = 0; i < nbits; i++) begin
         sclk = 1'b1;
         sdi  = bits[nbits-1-i];
         repeat (H) @(negedge clk);
         if (i < 16) rsp[15-i] = sdo;
         sclk = 1'b0;
         repeat (H) @(negedge clk);
         if (i == gap_at) begin
            repeat (40) @(negedge clk);
            check_ctrl("R3 outputs held during mid-frame pause");
         end
      end
      repeat (H) @(negedge clk);
      csn = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic frame(input int nbits, input logic [31:0] bits, input int gap_at,
                        input string tag);
      logic [15:0] exp, rsp;
      logic        was_fault;
      exp = exp_rsp();
      was_fault = m_fault;
      xfer(nbits, bits, gap_at, rsp);
      if (nbits >= 16) chk({tag, " R7 response word"}, 32'(rsp), 32'(exp));
      if (nbits >= 16 && was_fault) m_fault = 1'b0;
      if (nbits != 16) begin
         m_fault = 1'b1;
      end else begin
         if (!bits[15] && bits[14:11] < NC) m_ctrl[bits[14:11]] = bits[10:0];
         m_addr = bits[14:11];
      end
      check_ctrl({tag, " control outputs"});
      chk({tag, " R7 sdo low when idle"}, 32'(sdo), 32'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NC; i++) m_ctrl[i] = '0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check_ctrl("R9 reset control value");
      chk("R9 reset sdo", 32'(sdo), 32'd0);

      // R1: plain write then reads, MSB-first layout
      frame(16, 32'(mkw(1'b0, 0, 11'h155)), -1, "R1 write addr0");
      frame(16, 32'(mkw(1'b1, 0, 11'h000)), -1, "R1 read addr0");
      frame(16, 32'(mkw(1'b1, 0, 11'h000)), -1, "R1 reread addr0");

      // R8: every address written then read back
      for (int a = 0; a < 16; a++) begin
         logic [10:0] pat;
         pat = 11'((a * 291) ^ 677);
         frame(16, 32'(mkw(1'b0, a, pat)), -1, "R8 sweep write");
         frame(16, 32'(mkw(1'b1, a, 11'h000)), -1, "R8 sweep read");
      end

      // R2: split into two bursts with a long pause
      frame(16, 32'(mkw(1'b0, 1, 11'h6B2)), 7, "R2 split write");
      frame(16, 32'(mkw(1'b1, 1, 11'h000)), -1, "R2 split readback");

      // R4/R5/R6: short frame
      frame(12, 32'(mkw(1'b0, 0, 11'h7FF) >> 4), -1, "R4 short write");
      frame(16, 32'(mkw(1'b1, 0, 11'h000)), -1, "R5 fault reported");
      frame(16, 32'(mkw(1'b1, 0, 11'h000)), -1, "R6 fault cleared");

      // R4/R5/R6: long frame
      frame(20, {12'h0, mkw(1'b0, 1, 11'h001), 4'hA}, -1, "R4 long write");
      frame(16, 32'(mkw(1'b1, 1, 11'h000)), -1, "R5 fault after long");
      frame(16, 32'(mkw(1'b1, 2, 11'h000)), -1, "R6 fault gone");

      // R4: selection with no clocks
      frame(0, 32'd0, -1, "R4 empty select");
      frame(16, 32'(mkw(1'b1, 3, 11'h000)), -1, "R5 fault after empty");

      // R10: reads carrying data bits
      frame(16, 32'(mkw(1'b1, 0, 11'h7FF)), -1, "R10 read with data");
      frame(16, 32'(mkw(1'b1, 1, 11'h2AA)), -1, "R10 read with data");
      frame(16, 32'(mkw(1'b1, 1, 11'h000)), -1, "R10 final read");

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule